// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static Memory Controller

This block sits between a clocked host and an external 32-bit asynchronous static memory. The memory is built from four separate 8-bit banks. The banks share one 19-bit address bus and a single active-low output enable. Each bank has its own active-low chip enable and its own active-low write enable. The host gives one access at a time: address, write data, a 4-bit byte mask and a read/write flag. The controller turns it into strobe sequences whose widths are whole clock cycles, so every minimum timing window of the memory is met at the clock period set by a parameter.

Partial-width accesses (8, 16, 24 or 32 bits, contiguous or not) are made by pulsing chip enable and write enable only on the lanes whose mask bit is set. The controller also decides when the shared data bus is driven. During a write it keeps the output enable high for the whole access, so write data can be placed on the bus at once with no turnaround wait. During a read it never drives the bus.

Every access passes through five phases: idle, setup, strobe, hold and done. The done phase raises a one-cycle completion pulse, and on reads the captured data is valid during that pulse.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_done` is 0, all `mem_ce_n` and `mem_we_n` bits are 1, `mem_oe_n` is 1 and `mem_dq_oe` is 0.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the next cycle until the done cycle ends. Request inputs that change while the controller is busy have no effect on the access in progress.
- R3: Lane n is chip enable bit n and write enable bit n, and it carries data bits [8n+7:8n]. Only lanes whose `req_mask` bit is 1 see chip enable or write enable go low. A write enable bit is never low unless the chip enable bit of the same lane is also low.
- R4: During a write, `mem_oe_n` stays 1. `mem_dq_oe` is 1 from the setup cycle through the last hold cycle, and `mem_dq_out` carries the request data.
- R5: A write holds chip enable and write enable low on the selected lanes for exactly WR_CYC = ceil(20 ns / period) cycles. One setup cycle with the address and data already present comes first.
- R6: After the write strobe there are WH = max(1, ceil(5/T), ceil(2/T), ceil(25/T) - 1 - WR_CYC) hold cycles, where T is the period in ns. In these cycles the address and data stay driven and all strobes are high. `mem_dq_oe` is still 1 in the cycle in which write enable returns high.
- R7: A read holds chip enable low on the selected lanes, and `mem_oe_n` low, for exactly RD_CYC = ceil(max(25, 10) ns / period) cycles. Write enable stays high and `mem_dq_oe` stays 0 throughout. `mem_oe_n` is low only if at least one lane is selected.
- R8: Read data is sampled from `mem_dq_in` in the last strobe cycle. Lanes with mask bit 0 return zero in `rsp_rdata`, which is valid in the done cycle.
- R9: `rsp_done` is a one-cycle pulse. In the negedge-numbered count, where 0 is the request cycle, it comes in cycle WR_CYC+WH+2 for a write and in cycle RD_CYC+3 for a read.
- R10: An access with mask 0 strobes no lane but still finishes with the normal latency. If it is a read, it returns zero.
- R11: `mem_addr` holds the request address from setup through hold, and it does not change while any chip enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 32 | Write data |
| req_mask | input | 4 | Byte lanes to access |
| req_ready | output | 1 | Controller idle, request will be taken |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with rsp_done |
| mem_addr | output | 19 | Shared memory address |
| mem_ce_n | output | 4 | Per-lane chip enable, active low |
| mem_we_n | output | 4 | Per-lane write enable, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| mem_dq_out | output | 32 | Data toward memory |
| mem_dq_oe | output | 1 | Enables the data bus drivers |
| mem_dq_in | input | 32 | Data from memory |

## Verification
The assertions check, on every cycle, the protocol rules that any sequence must keep:
- no bus drive while output enable is low;
- write enable only inside chip enable, and never together with output enable;
- address stable under chip enable;
- minimum strobe widths;
- data held past the rising edge of write enable;
- a single-cycle done with ready following it.

Only the bench scenarios can show the rest. These are the exact cycle latency, that the lane-to-mask mapping lands the right bytes in the right banks, that unselected lanes read back as zero, and that busy-time request changes are ignored. The bench shows these by sweeping every mask over every address of a small memory model and comparing against a shadow image.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_DONE   = 3'd4
    } phase_e;

    // Round a nanosecond minimum up to whole clock periods.
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_lane_cnt.sv
module sram_lane_cnt #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
    import sram_lane_pkg::*;
#(
    parameter int AW      = 19,
    parameter int DW      = 32,
    parameter int LANES   = 4,
    parameter int CW      = 3,
    parameter int RD_STB  = 4,
    parameter int WR_STB  = 3,
    parameter int RD_HOLD = 1,
    parameter int WR_HOLD = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic [LANES-1:0] req_mask,
    input  logic             cnt_last,
    output phase_e           st_d,
    output phase_e           st_q,
    output logic             wr_d,
    output logic             wr_q,
    output logic [LANES-1:0] mask_d,
    output logic [LANES-1:0] mask_q,
    output logic [AW-1:0]    addr_q,
    output logic [DW-1:0]    wdata_q,
    output logic             cnt_load,
    output logic [CW-1:0]    cnt_val,
    output logic             req_ready
);
    localparam logic [CW-1:0] RD_STB_M1  = CW'(RD_STB - 1);
    localparam logic [CW-1:0] WR_STB_M1  = CW'(WR_STB - 1);
    localparam logic [CW-1:0] RD_HOLD_M1 = CW'(RD_HOLD - 1);
    localparam logic [CW-1:0] WR_HOLD_M1 = CW'(WR_HOLD - 1);

    typedef struct packed {
        phase_e           st;
        logic             wr;
        logic [LANES-1:0] mask;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    wdata;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d    = seq_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (seq_q.st)
            PH_IDLE: begin
                if (req_valid) begin
                    seq_d.st    = PH_SETUP;
                    seq_d.wr    = req_write;
                    seq_d.mask  = req_mask;
                    seq_d.addr  = req_addr;
                    seq_d.wdata = req_wdata;
                    cnt_load    = 1'b1;
                    cnt_val     = '0;
                end
            end
            PH_SETUP: begin
                if (cnt_last) begin
                    seq_d.st = PH_STROBE;
                    cnt_load = 1'b1;
                    cnt_val  = seq_q.wr ? WR_STB_M1 : RD_STB_M1;
                end
            end
            PH_STROBE: begin
                if (cnt_last) begin
                    seq_d.st = PH_HOLD;
                    cnt_load = 1'b1;
                    cnt_val  = seq_q.wr ? WR_HOLD_M1 : RD_HOLD_M1;
                end
            end
            PH_HOLD: begin
                if (cnt_last)
                    seq_d.st = PH_DONE;
            end
            PH_DONE: begin
                seq_d.st = PH_IDLE;
            end
            default: begin
                seq_d.st = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st    <= PH_IDLE;
            seq_q.wr    <= 1'b0;
            seq_q.mask  <= '0;
            seq_q.addr  <= '0;
            seq_q.wdata <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign st_d      = seq_d.st;
    assign st_q      = seq_q.st;
    assign wr_d      = seq_d.wr;
    assign wr_q      = seq_q.wr;
    assign mask_d    = seq_d.mask;
    assign mask_q    = seq_q.mask;
    assign addr_q    = seq_q.addr;
    assign wdata_q   = seq_q.wdata;
    assign req_ready = (seq_q.st == PH_IDLE);
endmodule

// File: rtl/sram_lane_strobe.sv
module sram_lane_strobe
    import sram_lane_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phase_e           st_d,
    input  logic             wr_d,
    input  logic [LANES-1:0] mask_d,
    output logic [LANES-1:0] ce_n,
    output logic [LANES-1:0] we_n,
    output logic             oe_n,
    output logic             dq_oe
);
    typedef struct packed {
        logic [LANES-1:0] ce_n;
        logic [LANES-1:0] we_n;
        logic             oe_n;
        logic             dq_oe;
    } stb_t;

    stb_t stb_d, stb_q;
    logic strobing;
    logic lane_ce_n_d [LANES];
    logic lane_we_n_d [LANES];

    assign strobing = (st_d == PH_STROBE);

    // Each lane decodes its own strobes from the phase and its mask bit.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_ce_n_d[g] = !(strobing && mask_d[g]);
        assign lane_we_n_d[g] = !(strobing && mask_d[g] && wr_d);
    end

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            stb_d.ce_n[i] = lane_ce_n_d[i];
            stb_d.we_n[i] = lane_we_n_d[i];
        end
        stb_d.oe_n  = !(strobing && !wr_d && (mask_d != '0));
        stb_d.dq_oe = wr_d && ((st_d == PH_SETUP) || (st_d == PH_STROBE) ||
                               (st_d == PH_HOLD));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_q.ce_n  <= '1;
            stb_q.we_n  <= '1;
            stb_q.oe_n  <= 1'b1;
            stb_q.dq_oe <= 1'b0;
        end else begin
            stb_q <= stb_d;
        end
    end

    assign ce_n  = stb_q.ce_n;
    assign we_n  = stb_q.we_n;
    assign oe_n  = stb_q.oe_n;
    assign dq_oe = stb_q.dq_oe;
endmodule

// File: rtl/sram_lane_rdcap.sv
module sram_lane_rdcap #(
    parameter int LANES = 4,
    parameter int LW    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_en,
    input  logic [LANES-1:0]    mask,
    input  logic [LANES*LW-1:0] dq_in,
    output logic [LANES*LW-1:0] rdata
);
    logic [LANES*LW-1:0] rd_d, rd_q;

    for (genvar g = 0; g < LANES; g++) begin : g_cap
        always_comb begin
            if (cap_en)
                rd_d[g*LW +: LW] = mask[g] ? dq_in[g*LW +: LW] : '0;
            else
                rd_d[g*LW +: LW] = rd_q[g*LW +: LW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_q <= '0;
        else
            rd_q <= rd_d;
    end

    assign rdata = rd_q;
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 8,
    parameter int AW            = 19,
    parameter int LANES         = 4,
    parameter int LW            = 8,
    parameter int T_READ_NS     = 25,
    parameter int T_OE_NS       = 10,
    parameter int T_WPULSE_NS   = 20,
    parameter int T_WGAP_NS     = 5,
    parameter int T_HOLD_NS     = 2,
    parameter int T_WCYC_NS     = 25
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [AW-1:0]       req_addr,
    input  logic [LANES*LW-1:0] req_wdata,
    input  logic [LANES-1:0]    req_mask,
    output logic                req_ready,
    output logic                rsp_done,
    output logic [LANES*LW-1:0] rsp_rdata,
    output logic [AW-1:0]       mem_addr,
    output logic [LANES-1:0]    mem_ce_n,
    output logic [LANES-1:0]    mem_we_n,
    output logic                mem_oe_n,
    output logic [LANES*LW-1:0] mem_dq_out,
    output logic                mem_dq_oe,
    input  logic [LANES*LW-1:0] mem_dq_in
);
    localparam int DW      = LANES * LW;
    localparam int RD_STB  = ns_to_cyc(imax(T_READ_NS, T_OE_NS), CLK_PERIOD_NS);
    localparam int WR_STB  = ns_to_cyc(T_WPULSE_NS, CLK_PERIOD_NS);
    localparam int RD_HOLD = 1;
    localparam int WR_HOLD = imax(imax(1, ns_to_cyc(T_WGAP_NS, CLK_PERIOD_NS)),
                                  imax(ns_to_cyc(T_HOLD_NS, CLK_PERIOD_NS),
                                       ns_to_cyc(T_WCYC_NS, CLK_PERIOD_NS) - 1 - WR_STB));
    localparam int MAX_CYC = imax(imax(RD_STB, WR_STB), imax(RD_HOLD, WR_HOLD));
    localparam int CW      = imax(1, $clog2(MAX_CYC + 1));

    phase_e           st_d, st_q;
    logic             wr_d, wr_q;
    logic [LANES-1:0] mask_d, mask_q;
    logic             cnt_load, cnt_last;
    logic [CW-1:0]    cnt_val;
    logic             cap_en;

    sram_lane_seq #(
        .AW(AW), .DW(DW), .LANES(LANES), .CW(CW),
        .RD_STB(RD_STB), .WR_STB(WR_STB),
        .RD_HOLD(RD_HOLD), .WR_HOLD(WR_HOLD)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_mask  (req_mask),
        .cnt_last  (cnt_last),
        .st_d      (st_d),
        .st_q      (st_q),
        .wr_d      (wr_d),
        .wr_q      (wr_q),
        .mask_d    (mask_d),
        .mask_q    (mask_q),
        .addr_q    (mem_addr),
        .wdata_q   (mem_dq_out),
        .cnt_load  (cnt_load),
        .cnt_val   (cnt_val),
        .req_ready (req_ready)
    );

    sram_lane_cnt #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .last     (cnt_last)
    );

    sram_lane_strobe #(.LANES(LANES)) u_stb (
        .clk    (clk),
        .rst_n  (rst_n),
        .st_d   (st_d),
        .wr_d   (wr_d),
        .mask_d (mask_d),
        .ce_n   (mem_ce_n),
        .we_n   (mem_we_n),
        .oe_n   (mem_oe_n),
        .dq_oe  (mem_dq_oe)
    );

    // Sample on the final strobe cycle of a read.
    assign cap_en = (st_q == PH_STROBE) && cnt_last && !wr_q;

    sram_lane_rdcap #(.LANES(LANES), .LW(LW)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .mask   (mask_q),
        .dq_in  (mem_dq_in),
        .rdata  (rsp_rdata)
    );

    assign rsp_done = (st_q == PH_DONE);
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk
    import sram_lane_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 8,
    parameter int AW            = 19,
    parameter int LANES         = 4,
    parameter int T_READ_NS     = 25,
    parameter int T_OE_NS       = 10,
    parameter int T_WPULSE_NS   = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             rsp_done,
    input logic [AW-1:0]    mem_addr,
    input logic [LANES-1:0] mem_ce_n,
    input logic [LANES-1:0] mem_we_n,
    input logic             mem_oe_n,
    input logic             mem_dq_oe
);
    localparam int WR_CYC = ns_to_cyc(T_WPULSE_NS, CLK_PERIOD_NS);
    localparam int RD_CYC = ns_to_cyc(imax(T_READ_NS, T_OE_NS), CLK_PERIOD_NS);

    logic [7:0] we_run, oe_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_run <= '0;
            oe_run <= '0;
        end else begin
            we_run <= (mem_we_n != '1) ? ((we_run == 8'hFF) ? we_run : we_run + 8'd1) : 8'd0;
            oe_run <= (!mem_oe_n) ? ((oe_run == 8'hFF) ? oe_run : oe_run + 8'd1) : 8'd0;
        end
    end

    // R7
    no_drive_under_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

    // R3
    we_inside_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~mem_we_n) & mem_ce_n) == '0);

    // R4
    we_with_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_n != '1) |-> (mem_oe_n && mem_dq_oe));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R2
    ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (!req_ready ##1 req_ready));

    // R11
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_ce_n != '1) && ($past(mem_ce_n) != '1)) |-> $stable(mem_addr));

    // R5
    we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we_n == '1) && (we_run != 8'd0)) |-> (we_run >= 8'(WR_CYC)));

    // R7
    oe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_oe_n && (oe_run != 8'd0)) |-> (oe_run >= 8'(RD_CYC)));

    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(mem_we_n) != '1) && (mem_we_n == '1)) |-> mem_dq_oe);
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .AW            (AW),
    .LANES         (LANES),
    .T_READ_NS     (T_READ_NS),
    .T_OE_NS       (T_OE_NS),
    .T_WPULSE_NS   (T_WPULSE_NS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_lane_ctrl_test.sv
`timescale 1ns/1ps
module sram_lane_ctrl_test;
    localparam int PER     = 8;
    localparam int WR_CYC  = (20 + PER - 1) / PER;
    localparam int RD_CYC  = (25 + PER - 1) / PER;
    localparam int WC_CYC  = (25 + PER - 1) / PER;
    localparam int WH_A    = ((5 + PER - 1) / PER > 1) ? (5 + PER - 1) / PER : 1;
    localparam int WH      = (WC_CYC - 1 - WR_CYC > WH_A) ? WC_CYC - 1 - WR_CYC : WH_A;
    localparam int WR_LAT  = WR_CYC + WH + 2;
    localparam int RD_LAT  = RD_CYC + 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_mask = '0;
    logic        req_ready, rsp_done, mem_oe_n, mem_dq_oe;
    logic [31:0] rsp_rdata, mem_dq_out, mem_dq_in;
    logic [18:0] mem_addr;
    logic [3:0]  mem_ce_n, mem_we_n;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] mem    [16];
    logic [31:0] shadow [16];

    always #(PER / 2) clk = ~clk;

    sram_lane_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    // Memory model: lanes drive only when selected for read, else a marker.
    always_comb begin
        for (int i = 0; i < 4; i++)
            mem_dq_in[i*8 +: 8] = (!mem_ce_n[i] && !mem_oe_n && mem_we_n[i])
                                  ? mem[mem_addr[3:0]][i*8 +: 8] : 8'hA5;
    end

    always @(negedge clk) begin
        for (int i = 0; i < 4; i++)
            if (!mem_ce_n[i] && !mem_we_n[i] && mem_dq_oe)
                mem[mem_addr[3:0]][i*8 +: 8] <= mem_dq_out[i*8 +: 8];
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [18:0] a, input logic [31:0] d,
                          input logic [3:0] m);
        int k;
        int ce_cnt [4];
        int we_cnt [4];
        bit addr_ok, oe_ok, drv_ok;
        logic [31:0] exp_rd;
        for (int i = 0; i < 4; i++) begin ce_cnt[i] = 0; we_cnt[i] = 0; end
        addr_ok = 1; oe_ok = 1; drv_ok = 1;
        @(negedge clk);
        check(req_ready == 1'b1, "R2 ready before request", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        k = 0;
        do begin
            @(negedge clk);
            k++;
            // R2: keep asking with junk while busy; it must not disturb the access
            req_addr = ~a; req_wdata = ~d; req_mask = ~m; req_write = ~wr;
            for (int i = 0; i < 4; i++) begin
                if (!mem_ce_n[i]) ce_cnt[i]++;
                if (!mem_we_n[i]) we_cnt[i]++;
            end
            if (!rsp_done && mem_addr != a) addr_ok = 0;
            if (wr && !mem_oe_n) oe_ok = 0;
            if (wr && !rsp_done && (!mem_dq_oe || mem_dq_out != d)) drv_ok = 0;
            if (!wr && mem_dq_oe) drv_ok = 0;
        end while (!rsp_done && k < 60);
        req_valid = 1'b0;
        check(k == (wr ? WR_LAT : RD_LAT), "R9 done latency", k, wr ? WR_LAT : RD_LAT);
        check(addr_ok, "R11 address held", mem_addr, a);
        if (wr) begin
            check(oe_ok, "R4 oe high during write", {31'd0, oe_ok}, 32'd1);
            check(drv_ok, "R4 data driven during write", {31'd0, drv_ok}, 32'd1);
        end else begin
            check(drv_ok, "R7 no drive during read", {31'd0, drv_ok}, 32'd1);
        end
        for (int i = 0; i < 4; i++) begin
            if (wr) begin
                check(we_cnt[i] == (m[i] ? WR_CYC : 0), "R5 R3 write strobe width",
                      we_cnt[i], m[i] ? WR_CYC : 0);
                check(ce_cnt[i] == (m[i] ? WR_CYC : 0), "R10 R3 write ce width",
                      ce_cnt[i], m[i] ? WR_CYC : 0);
            end else begin
                check(ce_cnt[i] == (m[i] ? RD_CYC : 0), "R7 R3 read ce width",
                      ce_cnt[i], m[i] ? RD_CYC : 0);
                check(we_cnt[i] == 0, "R7 read we high", we_cnt[i], 0);
            end
        end
        if (wr) begin
            for (int i = 0; i < 4; i++)
                if (m[i]) shadow[a[3:0]][i*8 +: 8] = d[i*8 +: 8];
        end else begin
            for (int i = 0; i < 4; i++)
                exp_rd[i*8 +: 8] = m[i] ? shadow[a[3:0]][i*8 +: 8] : 8'h00;
            check(rsp_rdata == exp_rd, "R8 R10 read data", rsp_rdata, exp_rd);
        end
        @(negedge clk);
        check(req_ready == 1'b1, "R2 ready after done", {31'd0, req_ready}, 32'd1);
        check(mem_dq_oe == 1'b0 && mem_ce_n == 4'hF, "R6 bus idle after access",
              {mem_dq_oe, 27'd0, mem_ce_n}, 32'h0000000F);
    endtask

    initial begin
        #(PER * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin mem[i] = 32'h0; shadow[i] = 32'h0; end
        repeat (3) @(negedge clk);
        // R1 reset state
        check(req_ready == 1 && rsp_done == 0, "R1 ready/done in reset",
              {30'd0, req_ready, rsp_done}, 32'd2);
        check(mem_ce_n == 4'hF && mem_we_n == 4'hF && mem_oe_n && !mem_dq_oe,
              "R1 strobes in reset", {22'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe},
              {22'd0, 4'hF, 4'hF, 1'b1, 1'b0});
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_ce_n == 4'hF && mem_we_n == 4'hF && mem_oe_n && !mem_dq_oe && req_ready,
              "R1 idle after reset", {27'd0, mem_ce_n, req_ready}, 32'h1F);
        // Fill every word with full-width writes.
        for (int a = 0; a < 16; a++)
            access(1'b1, 19'(a) | 19'h40000, 32'h1357_9BDF ^ (32'h0101_0101 * a), 4'hF);
        // Partial writes: each address gets the mask equal to its index.
        for (int a = 0; a < 16; a++)
            access(1'b1, 19'(a) | 19'h40000, 32'hC0DE_0000 + (32'h0011_0011 * a), 4'(a));
        // Read every address back with every mask.
        for (int a = 0; a < 16; a++)
            for (int m = 0; m < 16; m++)
                access(1'b0, 19'(a) | 19'h40000, 32'h0, 4'(m));
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule